// File: doc/BRIEF.md
# Link test pattern generator and checker

This block produces a 120-bit test frame on every frame clock and checks a frame stream that comes back over a link. The generator can produce one of three patterns: a fixed alternating A/B nibble constant, a set of packed copies of a free-running counter, or a PRBS7 value repeated across the frame. Every frame starts with the same 4-bit header. The pattern is picked by a 2-bit select input. Serializing the frames and carrying them over the link are done by other blocks.

The checker compares each valid received frame with a frame it builds locally for the same pattern. Two states control it. In `ST_SEARCH` it looks for a run of consecutive matches. In the counter and PRBS patterns it also realigns its local expectation to the received data on every valid frame. Four matches in a row take the transition *acquire* into `ST_LOCKED`. In `ST_LOCKED` the expectation advances on its own, and every mismatch adds one to a saturating error counter. Four mismatches in a row take the transition *drop* back to `ST_SEARCH`. Frames without valid have no effect in either state.

Top module: `pattern_link_tester`

## Requirements
- R1: Bits 119:116 of every generated frame hold the header 4'b0101, whatever the pattern.
- R2: Select codes 0 and 3 give the fixed pattern. Its bits 115:0 are 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB.
- R3: Select code 1 gives the counter pattern, {header, c[25:0], c, c, c}, where c is a 30-bit count. The count is 0 in reset and increases by 1 on every clock.
- R4: Select code 2 gives the PRBS pattern, {header, 4'h0, 16 copies of p}, with copy k at bits 7k+6:7k. p is 7'h7F in reset, steps to {p[5:0], p[6]^p[5]} on every clock, and is never zero.
- R5: A frame presented with rx_valid low changes neither the error count nor the lock flag.
- R6: In search, four consecutive valid matching frames raise `locked` at the clock edge of the fourth frame.
- R7: In the counter and PRBS patterns, each valid frame seen in search sets the next expectation from that frame: the count plus 1, or the PRBS step of bits 6:0. A consistent stream therefore raises `locked` on its fifth frame after reset.
- R8: The error count is 0 after reset. Mismatches seen while locked each add one. Mismatches seen in search add nothing.
- R9: Four consecutive valid mismatches while locked clear `locked`. A matching frame between mismatches restarts that run.
- R10: The error count saturates at its all-ones value.
- R11: In the PRBS pattern, a frame in search whose bits 6:0 are zero leaves the expectation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Pattern select: 0 fixed, 1 counter, 2 PRBS, 3 fixed |
| tx_frame | output | 120 | Generated test frame |
| rx_frame | input | 120 | Received frame |
| rx_valid | input | 1 | rx_frame holds a frame this cycle |
| err_count | output | 32 | Saturating mismatch count while locked |
| locked | output | 1 | Checker is in the locked state |

## Verification
The assertions check on every cycle that:
- the generator count steps by one and the PRBS state never reaches zero;
- the lock flag rises only on a valid frame and falls only on a valid mismatch;
- the error count never decreases and moves only on valid frames while locked;
- idle cycles leave the checker unchanged.

The following can only be shown by the bench scenarios:
- the exact bit layout of each pattern;
- the four-frame and five-frame lock points;
- realignment from received data, and its refusal of a zero PRBS field;
- the count value after a burst of errors;
- saturation, shown with a narrow counter instance.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
    localparam int FRAME_W   = 120;
    localparam int CNT_W     = 30;
    localparam int PRBS_W    = 7;
    localparam int PRBS_REPS = 16;
    localparam logic [3:0] HDR = 4'b0101;
    localparam logic [115:0] FIXED_BODY = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;

    typedef enum logic [1:0] {
        PAT_FIXED = 2'd0,
        PAT_COUNT = 2'd1,
        PAT_PRBS  = 2'd2,
        PAT_ALT   = 2'd3
    } pat_e;

    function automatic logic [PRBS_W-1:0] prbs_next(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[6] ^ s[5]};
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(input pat_e m,
                                                       input logic [CNT_W-1:0] c,
                                                       input logic [PRBS_W-1:0] p);
        logic [FRAME_W-1:0] f;
        f = '0;
        case (m)
            PAT_COUNT: f = {HDR, c[25:0], c, c, c};
            PAT_PRBS: begin
                f[FRAME_W-1 -: 8] = {HDR, 4'h0};
                for (int i = 0; i < PRBS_REPS; i++) f[i*PRBS_W +: PRBS_W] = p;
            end
            default: f = {HDR, FIXED_BODY};
        endcase
        return f;
    endfunction
endpackage

// File: rtl/ltp_gen.sv
module ltp_gen
    import ltp_pkg::*;
#(
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h7F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pat_e               mode,
    output logic [FRAME_W-1:0] frame
);
    logic [CNT_W-1:0]  cnt_q;
    logic [PRBS_W-1:0] prbs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prbs_q <= PRBS_SEED;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            prbs_q <= prbs_next(prbs_q);
        end
    end

    always_comb frame = build_frame(mode, cnt_q, prbs_q);

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    a_r4_prbs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_q != '0);
endmodule

// File: rtl/ltp_chk.sv
module ltp_chk
    import ltp_pkg::*;
#(
    parameter int LOCK_RUN = 4,
    parameter int LOSS_RUN = 4,
    parameter int ERR_W    = 32,
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h7F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pat_e               mode,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rx_valid,
    output logic [ERR_W-1:0]   err_count,
    output logic               locked
);
    localparam int RUN_MAX = (LOCK_RUN > LOSS_RUN) ? LOCK_RUN : LOSS_RUN;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);

    typedef enum logic {ST_SEARCH, ST_LOCKED} st_e;

    st_e               state_q, state_d;
    logic [CNT_W-1:0]  exp_cnt_q, exp_cnt_d;
    logic [PRBS_W-1:0] exp_prbs_q, exp_prbs_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic [ERR_W-1:0]  err_q, err_d;
    logic              match, seed_ok;

    assign match   = (rx_frame == build_frame(mode, exp_cnt_q, exp_prbs_q));
    assign seed_ok = (mode != PAT_PRBS) || (rx_frame[PRBS_W-1:0] != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SEARCH;
            exp_cnt_q  <= '0;
            exp_prbs_q <= PRBS_SEED;
            run_q      <= '0;
            err_q      <= '0;
        end else begin
            state_q    <= state_d;
            exp_cnt_q  <= exp_cnt_d;
            exp_prbs_q <= exp_prbs_d;
            run_q      <= run_d;
            err_q      <= err_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        exp_cnt_d  = exp_cnt_q;
        exp_prbs_d = exp_prbs_q;
        run_d      = run_q;
        err_d      = err_q;
        if (rx_valid) begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (seed_ok) begin
                        exp_cnt_d  = rx_frame[CNT_W-1:0] + CNT_W'(1);
                        exp_prbs_d = prbs_next(rx_frame[PRBS_W-1:0]);
                    end
                    if (!match) begin
                        run_d = '0;
                    end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                        state_d = ST_LOCKED;   // acquire
                        run_d   = '0;
                    end else begin
                        run_d = run_q + RUN_W'(1);
                    end
                end
                ST_LOCKED: begin
                    exp_cnt_d  = exp_cnt_q + CNT_W'(1);
                    exp_prbs_d = prbs_next(exp_prbs_q);
                    if (match) begin
                        run_d = '0;
                    end else begin
                        if (err_q != '1) err_d = err_q + ERR_W'(1);
                        if (run_q == RUN_W'(LOSS_RUN - 1)) begin
                            state_d = ST_SEARCH;   // drop
                            run_d   = '0;
                        end else begin
                            run_d = run_q + RUN_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        locked    = (state_q == ST_LOCKED);
        err_count = err_q;
    end

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(state_q) && $stable(err_q) && $stable(exp_cnt_q));
    a_r6_lock_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rx_valid) && $past(match));
    a_r8_err_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && state_q == ST_LOCKED) |=> $stable(err_q));
    a_r9_drop_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(rx_valid) && !$past(match));
    a_r10_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> err_q >= $past(err_q));
endmodule

// File: rtl/pattern_link_tester.sv
module pattern_link_tester
    import ltp_pkg::*;
#(
    parameter int LOCK_RUN = 4,
    parameter int LOSS_RUN = 4,
    parameter int ERR_W    = 32,
    parameter logic [6:0] PRBS_SEED = 7'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    output logic [119:0]     tx_frame,
    input  logic [119:0]     rx_frame,
    input  logic             rx_valid,
    output logic [ERR_W-1:0] err_count,
    output logic             locked
);
    pat_e mode;
    assign mode = pat_e'(mode_sel);

    ltp_gen #(.PRBS_SEED(PRBS_SEED)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .frame (tx_frame)
    );

    ltp_chk #(
        .LOCK_RUN  (LOCK_RUN),
        .LOSS_RUN  (LOSS_RUN),
        .ERR_W     (ERR_W),
        .PRBS_SEED (PRBS_SEED)
    ) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rx_frame  (rx_frame),
        .rx_valid  (rx_valid),
        .err_count (err_count),
        .locked    (locked)
    );
endmodule

// File: tb/tb_pattern_link_tester.sv
module tb_pattern_link_tester;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic [119:0] rx_frame = '0;
    logic         rx_valid = 1'b0;
    logic [119:0] tx_frame, tx_frame2;
    logic [31:0]  err_count;
    logic [2:0]   err_small;
    logic         locked, locked2;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    pattern_link_tester dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_frame(tx_frame),
        .rx_frame(rx_frame), .rx_valid(rx_valid), .err_count(err_count), .locked(locked)
    );

    pattern_link_tester #(.ERR_W(3)) dut_sat (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_frame(tx_frame2),
        .rx_frame(rx_frame), .rx_valid(rx_valid), .err_count(err_small), .locked(locked2)
    );

    localparam logic [115:0] FIX = 116'hAAA_BBBB_AAAA_BBBB_AAAA_BBBB_AAAA_BB;

    function automatic logic [119:0] f_fix();
        return {4'b0101, FIX};
    endfunction
    function automatic logic [119:0] f_cnt(input logic [29:0] c);
        return {4'b0101, c[25:0], c, c, c};
    endfunction
    function automatic logic [119:0] f_prbs(input logic [6:0] p);
        return {4'b0101, 4'h0, {16{p}}};
    endfunction
    function automatic logic [6:0] step(input logic [6:0] p);
        return {p[5:0], p[6] ^ p[5]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0; rx_valid = 1'b0; mode_sel = m;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [119:0] f, input logic v);
        @(negedge clk);
        rx_frame = f; rx_valid = v;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0; mode_sel = 2'd0;
        @(negedge clk);
        check("R8 err zero in reset", 128'(err_count), 128'd0);
        check("R6 unlocked in reset", 128'(locked), 128'd0);
        check("R2 fixed frame", 128'(tx_frame), 128'(f_fix()));
        mode_sel = 2'd3; #1;
        check("R2 code 3 fixed", 128'(tx_frame), 128'(f_fix()));
        mode_sel = 2'd1; #1;
        check("R3 count zero in reset", 128'(tx_frame), 128'(f_cnt(30'd0)));
        mode_sel = 2'd2; #1;
        check("R4 prbs seed in reset", 128'(tx_frame), 128'(f_prbs(7'h7F)));
        rst_n = 1'b1;
    endtask

    task automatic t_gen_patterns();
        logic [119:0] a, b;
        do_reset(2'd1);
        repeat (3) @(negedge clk);
        a = tx_frame;
        @(negedge clk);
        b = tx_frame;
        check("R1 header counter", 128'(a[119:116]), 128'h5);
        check("R3 counter layout", 128'(a), 128'(f_cnt(a[29:0])));
        check("R3 counter step", 128'(b), 128'(f_cnt(a[29:0] + 30'd1)));
        mode_sel = 2'd2;
        @(negedge clk);
        a = tx_frame;
        @(negedge clk);
        b = tx_frame;
        check("R1 header prbs", 128'(a[119:116]), 128'h5);
        check("R4 prbs layout", 128'(a), 128'(f_prbs(a[6:0])));
        check("R4 prbs step", 128'(b), 128'(f_prbs(step(a[6:0]))));
        check("R4 prbs nonzero", 128'(a[6:0] != 7'd0), 128'd1);
    endtask

    task automatic t_fixed_lock();
        do_reset(2'd0);
        repeat (3) send(f_fix(), 1'b1);
        check("R6 not locked after 3", 128'(locked), 128'd0);
        send(f_fix(), 1'b1);
        check("R6 locked after 4", 128'(locked), 128'd1);
        send(f_fix() ^ (120'd1 << 50), 1'b0);
        check("R5 invalid ignored err", 128'(err_count), 128'd0);
        check("R5 invalid ignored lock", 128'(locked), 128'd1);
    endtask

    task automatic t_count_lock_errors();
        do_reset(2'd1);
        for (int i = 0; i < 4; i++) send(f_cnt(30'd1000 + 30'(i)), 1'b1);
        check("R7 not locked after 4", 128'(locked), 128'd0);
        check("R8 search miss not counted", 128'(err_count), 128'd0);
        send(f_cnt(30'd1004), 1'b1);
        check("R7 locked on fifth", 128'(locked), 128'd1);
        send(f_cnt(30'd1005) ^ (120'd1 << 100), 1'b1);
        check("R8 one error", 128'(err_count), 128'd1);
        check("R9 single miss keeps lock", 128'(locked), 128'd1);
        send(f_cnt(30'd1006), 1'b1);
        check("R8 good frame no error", 128'(err_count), 128'd1);
        for (int i = 0; i < 3; i++) send(f_cnt(30'd1007 + 30'(i)) ^ 120'd1, 1'b1);
        check("R9 three misses keep lock", 128'(locked), 128'd1);
        send(f_cnt(30'd1010) ^ 120'd1, 1'b1);
        check("R9 fourth miss drops lock", 128'(locked), 128'd0);
        check("R8 error count after burst", 128'(err_count), 128'd5);
    endtask

    task automatic t_prbs_lock();
        logic [6:0] p;
        do_reset(2'd2);
        for (int i = 0; i < 6; i++) send({4'b0101, 116'd0}, 1'b1);
        check("R11 zero field no lock", 128'(locked), 128'd0);
        p = 7'h35;
        for (int i = 0; i < 4; i++) begin
            send(f_prbs(p), 1'b1);
            p = step(p);
        end
        check("R7 prbs not locked after 4", 128'(locked), 128'd0);
        send(f_prbs(p), 1'b1);
        check("R7 prbs locked on fifth", 128'(locked), 128'd1);
    endtask

    task automatic t_saturate();
        do_reset(2'd0);
        for (int i = 0; i < 4; i++) send(f_fix(), 1'b1);
        check("R6 narrow instance locked", 128'(locked2), 128'd1);
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 3; i++) send(f_fix() ^ 120'd2, 1'b1);
            send(f_fix(), 1'b1);
        end
        check("R9 match restarts miss run", 128'(locked2), 128'd1);
        check("R10 saturated count", 128'(err_small), 128'd7);
    endtask

    initial begin
        t_reset_state();
        t_gen_patterns();
        t_fixed_lock();
        t_count_lock_errors();
        t_prbs_lock();
        t_saturate();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule